// File: doc/BRIEF.md
# Memory access permission checker

This block decides, for one memory access at a time, whether the permission attributes of an already translated page allow that access. Each request gives the page's 2-bit access-permission field, its two execute-never bits (one per privilege level) and a device-region flag. It also gives the kind of access, the privilege the access is made at, a flag marking an explicitly unprivileged load or store, and two control bits. The first control bit stops privileged code from touching data that unprivileged code can reach. The second makes every location that is writable at the current privilege non-executable at that privilege.

The verdict is registered. One clock after a valid request, the block presents a result strobe, an allow or fault indication and a 2-bit cause code. Translation, table walks, TLB storage and exception delivery belong to the surrounding pipeline. This block only produces the verdict that the pipeline turns into a permission fault.

Top module: `mpc_perm_checker`

## Requirements
- R1: The permission field grants rights by privilege. Value 0 gives unprivileged no access and privileged read/write. Value 1 gives read/write at both levels. Value 2 gives unprivileged no access and privileged read only. Value 3 gives read only at both levels.
- R2: A load lacking read right or a store lacking write right at its checking privilege is refused with cause 1 (read/write permission). This includes a privileged store to a field value of 2 or 3.
- R3: When the data-protection control is 1, an ordinary privileged load or store to a page readable by unprivileged code (field value 1 or 3) is refused with cause 2. If the same access also breaks R2, cause 1 is reported instead.
- R4: A load or store whose unprivileged flag is 1 is judged against the unprivileged rights of R1 even when the privilege input is 1.
- R5: A load or store whose unprivileged flag is 1 never receives cause 2, whatever the data-protection control holds.
- R6: A fetch (access kind 2) made at unprivileged level is refused with cause 3 when the unprivileged execute-never bit is 1. A fetch made at privileged level is refused with cause 3 when the privileged execute-never bit is 1.
- R7: A privileged fetch from a page with field value 1 is refused with cause 3 even when both execute-never bits are 0.
- R8: When the write-implies-no-execute control is 1, a fetch from a page writable at the fetch's own privilege is refused with cause 3. Cause 3 is also reported when an execute-never bit applies at the same time.
- R9: A fetch from a page whose device flag is 1 is refused with cause 3 at either privilege.
- R10: Access kind is encoded 0 = load, 1 = store, 2 = fetch, 3 = load. A fetch ignores the read/write rights, the data-protection control and the unprivileged flag, so it never receives cause 1 or 2. A load or store never receives cause 3.
- R11: The result strobe rises exactly one clock after a request strobe. With it, exactly one of allow and fault is 1, and the cause is 0 when allowed. After a clock with no request, the result strobe, allow, fault and cause are all 0.
- R12: While reset is asserted, all outputs are 0 regardless of the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one access per clock |
| req_ap | input | 2 | Page access-permission field |
| req_uxn | input | 1 | Unprivileged execute-never bit |
| req_pxn | input | 1 | Privileged execute-never bit |
| req_dev | input | 1 | Device-region flag |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_priv | input | 1 | Current privilege: 0 unprivileged, 1 privileged |
| req_unpriv_ldst | input | 1 | Load/store explicitly made as unprivileged |
| ctl_pan | input | 1 | Privileged code barred from unprivileged-readable data |
| ctl_wxn | input | 1 | Writable implies no execute |
| res_vld | output | 1 | Result strobe, one clock after req_vld |
| res_allow | output | 1 | Access permitted |
| res_fault | output | 1 | Permission fault |
| res_cause | output | 2 | 0 none, 1 read/write, 2 data protection, 3 execute-never |

## Verification
Two rules can fall on the same access, and the cause code shows which one wins. A privileged store to a read-only page that unprivileged code can read, with the data-protection control set, breaks both the write right and the data-protection rule; it must report cause 1. A fetch from a writable page with write-implies-no-execute on and an execute-never bit also set must report cause 3. The bench sweeps every combination of all request and control inputs and, on top of that, drives these overlaps as directed cases. It also mixes in seeded random traffic with idle gaps. Each registered verdict is compared one clock later with a reference function that restates the rights as a lookup table.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int AP_W    = 2;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_LOAD2 = 2'd3
  } acc_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_RW   = 2'd1,
    CAUSE_PAN  = 2'd2,
    CAUSE_XN   = 2'd3
  } cause_e;

  // Read right: privileged level may always read; unprivileged only for 1 and 3.
  function automatic logic ap_can_read(input logic [AP_W-1:0] ap, input logic lvl);
    return lvl ? 1'b1 : ap[0];
  endfunction

  // Write right: privileged for 0 and 1, unprivileged only for 1.
  function automatic logic ap_can_write(input logic [AP_W-1:0] ap, input logic lvl);
    return lvl ? ~ap[1] : (ap == 2'd1);
  endfunction

  // Page reachable by unprivileged code at all.
  function automatic logic ap_user_visible(input logic [AP_W-1:0] ap);
    return ap[0];
  endfunction

  // Priority: execute rules, then read/write rights, then data protection.
  function automatic cause_e pick_cause(input logic rw, input logic pan, input logic xn);
    if (xn)  return CAUSE_XN;
    if (rw)  return CAUSE_RW;
    if (pan) return CAUSE_PAN;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/mpc_data_chk.sv
module mpc_data_chk
  import mpc_pkg::*;
(
  input  logic [AP_W-1:0]   ap,
  input  logic [KIND_W-1:0] kind,
  input  logic              priv,
  input  logic              unpriv_ldst,
  input  logic              pan_en,
  output logic              rw_viol,
  output logic              pan_viol
);

  logic is_data;
  logic is_store;
  logic chk_lvl;
  logic right_ok;

  always_comb begin
    is_data  = (acc_kind_e'(kind) != KIND_FETCH);
    is_store = (acc_kind_e'(kind) == KIND_STORE);
    // Explicitly unprivileged loads/stores use the unprivileged column.
    chk_lvl  = priv & ~unpriv_ldst;
    right_ok = is_store ? ap_can_write(ap, chk_lvl) : ap_can_read(ap, chk_lvl);
    rw_viol  = is_data & ~right_ok;
    pan_viol = is_data & pan_en & priv & ~unpriv_ldst & ap_user_visible(ap);
  end

endmodule

// File: rtl/mpc_exec_chk.sv
module mpc_exec_chk
  import mpc_pkg::*;
(
  input  logic [AP_W-1:0]   ap,
  input  logic [KIND_W-1:0] kind,
  input  logic              priv,
  input  logic              uxn,
  input  logic              pxn,
  input  logic              dev,
  input  logic              wxn_en,
  output logic              xn_viol
);

  logic is_fetch;
  logic xn_bit_hit;
  logic user_wr_hit;
  logic wxn_hit;

  always_comb begin
    is_fetch    = (acc_kind_e'(kind) == KIND_FETCH);
    xn_bit_hit  = priv ? pxn : uxn;
    // Unprivileged-writable pages never run privileged code.
    user_wr_hit = priv & ap_can_write(ap, 1'b0);
    wxn_hit     = wxn_en & ap_can_write(ap, priv);
    xn_viol     = is_fetch & (xn_bit_hit | dev | user_wr_hit | wxn_hit);
  end

endmodule

// File: rtl/mpc_result_reg.sv
module mpc_result_reg
  import mpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic               rw_viol,
  input  logic               pan_viol,
  input  logic               xn_viol,
  output logic               res_vld,
  output logic               res_allow,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause
);

  cause_e cause_nxt;

  always_comb cause_nxt = pick_cause(rw_viol, pan_viol, xn_viol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_allow <= 1'b0;
      res_fault <= 1'b0;
      res_cause <= CAUSE_NONE;
    end else begin
      res_vld <= req_vld;
      if (req_vld) begin
        res_allow <= (cause_nxt == CAUSE_NONE);
        res_fault <= (cause_nxt != CAUSE_NONE);
        res_cause <= cause_nxt;
      end else begin
        res_allow <= 1'b0;
        res_fault <= 1'b0;
        res_cause <= CAUSE_NONE;
      end
    end
  end

endmodule

// File: rtl/mpc_perm_checker.sv
module mpc_perm_checker
  import mpc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [AP_W-1:0]    req_ap,
  input  logic               req_uxn,
  input  logic               req_pxn,
  input  logic               req_dev,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_priv,
  input  logic               req_unpriv_ldst,
  input  logic               ctl_pan,
  input  logic               ctl_wxn,
  output logic               res_vld,
  output logic               res_allow,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause
);

  // Named verdict wires, visible to the bound checker.
  logic rw_viol;
  logic pan_viol;
  logic xn_viol;

  mpc_data_chk u_data (
    .ap          (req_ap),
    .kind        (req_kind),
    .priv        (req_priv),
    .unpriv_ldst (req_unpriv_ldst),
    .pan_en      (ctl_pan),
    .rw_viol     (rw_viol),
    .pan_viol    (pan_viol)
  );

  mpc_exec_chk u_exec (
    .ap      (req_ap),
    .kind    (req_kind),
    .priv    (req_priv),
    .uxn     (req_uxn),
    .pxn     (req_pxn),
    .dev     (req_dev),
    .wxn_en  (ctl_wxn),
    .xn_viol (xn_viol)
  );

  mpc_result_reg u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .rw_viol   (rw_viol),
    .pan_viol  (pan_viol),
    .xn_viol   (xn_viol),
    .res_vld   (res_vld),
    .res_allow (res_allow),
    .res_fault (res_fault),
    .res_cause (res_cause)
  );

endmodule

// File: rtl/mpc_perm_checker_sva.sv
module mpc_perm_checker_sva
  import mpc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_vld,
  input logic [AP_W-1:0]    req_ap,
  input logic               req_uxn,
  input logic               req_pxn,
  input logic               req_dev,
  input logic [KIND_W-1:0]  req_kind,
  input logic               req_priv,
  input logic               req_unpriv_ldst,
  input logic               ctl_pan,
  input logic               ctl_wxn,
  input logic               res_vld,
  input logic               res_allow,
  input logic               res_fault,
  input logic [CAUSE_W-1:0] res_cause,
  input logic               rw_viol,
  input logic               pan_viol,
  input logic               xn_viol
);

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);  // R11
  AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!res_vld && !res_allow && !res_fault && res_cause == 2'd0));  // R11
  AST_ALLOW_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_allow != res_fault));  // R11
  AST_CAUSE_TRACKS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_fault == (res_cause != 2'd0)));  // R11
  AST_PRIV_STORE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd1 && req_priv && !req_unpriv_ldst && req_ap[1])
      |=> res_cause == 2'd1);  // R2
  AST_UNPRIV_SKIPS_PAN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_unpriv_ldst && req_kind != 2'd2 && ctl_pan) |=> res_cause != 2'd2);  // R5
  AST_XN_BIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && (req_priv ? req_pxn : req_uxn)) |=> res_cause == 2'd3);  // R6
  AST_USER_WR_NO_PRIV_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && req_priv && req_ap == 2'd1) |=> res_cause == 2'd3);  // R7
  AST_WXN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && ctl_wxn &&
     ((req_priv && !req_ap[1]) || (!req_priv && req_ap == 2'd1))) |=> res_cause == 2'd3);  // R8
  AST_DEVICE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 2'd2 && req_dev) |=> (res_fault && res_cause == 2'd3));  // R9
  AST_FETCH_NO_DATA_RULES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 2'd2) |-> (!rw_viol && !pan_viol));  // R10
  AST_DATA_NO_XN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind != 2'd2) |-> !xn_viol);  // R10

endmodule

bind mpc_perm_checker mpc_perm_checker_sva chk_i (.*);

// File: tb/mpc_perm_checker_tb_top.sv
`timescale 1ns/1ps
module mpc_perm_checker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_vld = 1'b0;
  logic [1:0] req_ap = 2'd0;
  logic       req_uxn = 1'b0;
  logic       req_pxn = 1'b0;
  logic       req_dev = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       req_priv = 1'b0;
  logic       req_unpriv_ldst = 1'b0;
  logic       ctl_pan = 1'b0;
  logic       ctl_wxn = 1'b0;
  logic       res_vld;
  logic       res_allow;
  logic       res_fault;
  logic [1:0] res_cause;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  mpc_perm_checker dut_i (.*);

  // Reference: rights table per field value {user rd, user wr, priv rd, priv wr}.
  function automatic logic [1:0] ref_cause(
    input logic [1:0] ap, input logic [1:0] kind, input logic priv, input logic up,
    input logic pan, input logic wxn, input logic uxn, input logic pxn, input logic dev);
    logic [3:0] rights;
    logic u_rd, u_wr, p_rd, p_wr, lvl, ok, wr_here;
    case (ap)
      2'd0:    rights = 4'b0011;
      2'd1:    rights = 4'b1111;
      2'd2:    rights = 4'b0010;
      default: rights = 4'b1010;
    endcase
    {u_rd, u_wr, p_rd, p_wr} = rights;
    if (kind == 2'd2) begin
      wr_here = priv ? p_wr : u_wr;
      if ((priv ? pxn : uxn) || dev || (priv && u_wr) || (wxn && wr_here)) return 2'd3;
      return 2'd0;
    end
    lvl = priv && !up;
    ok  = (kind == 2'd1) ? (lvl ? p_wr : u_wr) : (lvl ? p_rd : u_rd);
    if (!ok) return 2'd1;
    if (pan && lvl && u_rd) return 2'd2;
    return 2'd0;
  endfunction

  function automatic string tag_of(input logic [1:0] kind, input logic up, input logic pan);
    if (kind == 2'd2) return "R6 R7 R8 R9 R10";
    if (up)           return "R4 R5";
    if (pan)          return "R3";
    return "R1 R2";
  endfunction

  task automatic drive(input logic vld, input logic [1:0] ap, input logic [1:0] kind,
                       input logic priv, input logic up, input logic pan, input logic wxn,
                       input logic uxn, input logic pxn, input logic dev);
    req_vld = vld; req_ap = ap; req_kind = kind; req_priv = priv;
    req_unpriv_ldst = up; ctl_pan = pan; ctl_wxn = wxn;
    req_uxn = uxn; req_pxn = pxn; req_dev = dev;
  endtask

  task automatic check(input string tag, input logic exp_vld, input logic [1:0] exp_cause);
    logic [4:0] act, exp;
    act = {res_vld, res_allow, res_fault, res_cause};
    exp = {exp_vld, exp_vld && exp_cause == 2'd0, exp_vld && exp_cause != 2'd0,
           exp_vld ? exp_cause : 2'd0};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {vld,allow,fault,cause} actual %b expected %b", tag, act, exp);
    end
  endtask

  // One request, result sampled at the next falling edge.
  task automatic apply(input string tag, input logic vld, input logic [1:0] ap,
                       input logic [1:0] kind, input logic priv, input logic up,
                       input logic pan, input logic wxn, input logic uxn,
                       input logic pxn, input logic dev);
    drive(vld, ap, kind, priv, up, pan, wxn, uxn, pxn, dev);
    @(negedge clk);
    check(tag, vld, ref_cause(ap, kind, priv, up, pan, wxn, uxn, pxn, dev));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd4711);
    // R12: reset holds outputs low even with a request present.
    drive(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R12", 1'b0, 2'd0);
    end
    drive(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 R11", 1'b0, 2'd0);

    // Directed overlaps and corners.
    apply("R2 R3 overlap", 1'b1, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R3", 1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R4 R5", 1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R4", 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R7", 1'b1, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R8 R6 overlap", 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply("R8", 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    apply("R9", 1'b1, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply("R10", 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R10 kind3", 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R11 idle", 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    apply("R1", 1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Exhaustive sweep over every request and control combination, back to back.
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] v;
      v = 12'(i);
      apply(tag_of(v[3:2], v[5], v[6]), 1'b1, v[1:0], v[3:2], v[4], v[5], v[6],
            v[7], v[8], v[9], v[10]);
    end

    // Seeded random traffic with idle gaps (R11).
    for (int i = 0; i < 3000; i++) begin
      logic vld;
      r = $urandom;
      vld = (r[15:13] != 3'd0);
      apply(vld ? tag_of(r[3:2], r[5], r[6]) : "R11", vld, r[1:0], r[3:2], r[4], r[5],
            r[6], r[7], r[8], r[9], r[10]);
    end

    done = 1'b1;
    finish_run();
  end

endmodule